// File: doc/BRIEF.md
# Programmable Delay Trigger Timer

This block paces data converters. A free-running up-counter repeats a period of modulus+1 clocks. Two compare points inside that period produce the outputs. An interrupt-delay value marks the count at which a one-clock request pulse goes out, either as an interrupt or as a DMA request. A channel delay value marks the count at which a pre-trigger pulse goes to a downstream converter. The counter does not start by itself. Software enables the block and then writes a start bit. It runs either continuously or for a single period.

The modulus, the interrupt delay and the channel delay are double-buffered. Software writes the buffers, then sets a load bit. The buffered values move into the active registers at the next counter wrap, or on the next clock if the counter is stopped. The load bit then clears. This lets software retune the rate of a running stream without a torn period. A sticky status flag records each request until software clears it.

Top module: `dly_trig_timer`

## Requirements
- R1: In continuous mode (CTRL bit1=1) the counter reads 0,1,…,M and then 0 again, where M is the active modulus: a period of M+1 clocks. The counter reads at address 5 and the modulus at address 1.
- R2: In one-shot mode (CTRL bit1=0) the counter stops after count M and holds 0. A further start write runs exactly one more period.
- R3: A CTRL (address 0) write with bit3=1 starts the counter at 0 only if the same write has bit0=1 (enable). It is ignored while the counter is already running. CTRL read bit6 shows running.
- R4: While running, a one-clock request occurs at every count equal to the active interrupt delay (address 2), once per period. This holds for a delay of 0 and for a delay of 1.
- R5: With CTRL bit2=0 the request drives `irq`. With bit2=1 it drives `dma_req` instead, and `irq` stays low. The two are never high together.
- R6: Writes to addresses 1, 2 and 4 change only buffers, and reads of those addresses return the active values. CTRL bit4=1 requests a transfer, which happens at the next wrap, or on the next clock when stopped. While the transfer is pending, read bit4 is 1. Afterwards it reads 0.
- R7: The status flag (CTRL read bit5) sets on the clock after a request and stays set until a CTRL write with bit5=1. If the two coincide, setting wins.
- R8: Channel control (address 3) bit0 enables the pre-trigger and bit8 selects the delayed mode (0x0101 sets both). In delayed mode `pretrig` pulses at the count equal to the active channel delay (address 4). With bit8=0 it pulses at count 0. With bit0=0 it never pulses.
- R9: A CTRL write with bit0=0 stops the counter at 0 on the next clock. While disabled, `irq`, `dma_req` and `pretrig` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request pulse |
| dma_req | output | 1 | DMA request pulse |
| pretrig | output | 1 | Converter pre-trigger pulse |

## Verification
The bench targets the off-by-one in the period: a design that wraps at the modulus instead of after it would give M-count periods, and the count trace would drift from the expected sequence. It runs delays of 0 and 1, one-shot restarts and the no-delay pre-trigger mode, where a wrong compare would pulse at the wrong count or twice per period. It retunes a running counter, because a design that used buffered values at once would read back the new modulus early or cut the current period short. It also writes a start bit while running and while disabled, where a careless design would restart or begin counting.

// File: rtl/dly_trig_timer.sv
module dly_trig_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq,
  output logic          dma_req,
  output logic          pretrig
);
  localparam logic [2:0] A_CTRL = 3'd0, A_MOD = 3'd1, A_IDLY = 3'd2,
                         A_CHC  = 3'd3, A_CHD = 3'd4, A_CNT  = 3'd5;
  localparam int B_EN = 0, B_CONT = 1, B_DMA = 2, B_TRIG = 3, B_LOAD = 4,
                 B_FLAG = 5, B_RUN = 6, B_CHEN = 0, B_CHDLY = 8;

  logic          en, cont, dma_en, ldok, flag, run, ch_en, ch_dsel;
  logic [CW-1:0] cnt, mod_buf, mod_act, idly_buf, idly_act, cdly_buf, cdly_act;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wrap    = run && cnt == mod_act;
  wire start   = wr_ctrl && reg_wdata[B_TRIG] && reg_wdata[B_EN] && !run;
  wire stop    = wr_ctrl && !reg_wdata[B_EN];
  wire xfer    = ldok && (!run || wrap);
  wire req_hit = en && run && cnt == idly_act;

  assign irq     = req_hit && !dma_en;
  assign dma_req = req_hit && dma_en;
  assign pretrig = en && run && ch_en && (ch_dsel ? cnt == cdly_act : cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cont <= 1'b0; dma_en <= 1'b0;
    end else if (wr_ctrl) begin
      en     <= reg_wdata[B_EN];
      cont   <= reg_wdata[B_CONT];
      dma_en <= reg_wdata[B_DMA];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; cnt <= '0;
    end else if (stop) begin
      run <= 1'b0; cnt <= '0;
    end else if (start) begin
      run <= 1'b1; cnt <= '0;
    end else if (wrap) begin
      run <= cont; cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_buf <= '1; idly_buf <= '0; cdly_buf <= '0;
      ch_en <= 1'b0; ch_dsel <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_MOD:  mod_buf  <= reg_wdata;
        A_IDLY: idly_buf <= reg_wdata;
        A_CHD:  cdly_buf <= reg_wdata;
        A_CHC: begin
          ch_en   <= reg_wdata[B_CHEN];
          ch_dsel <= reg_wdata[B_CHDLY];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_act <= '1; idly_act <= '0; cdly_act <= '0;
    end else if (xfer) begin
      mod_act  <= mod_buf;
      idly_act <= idly_buf;
      cdly_act <= cdly_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ldok <= 1'b0;
    else if (wr_ctrl && reg_wdata[B_LOAD]) ldok <= 1'b1;
    else if (xfer)                         ldok <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            flag <= 1'b0;
    else if (req_hit)                      flag <= 1'b1;
    else if (wr_ctrl && reg_wdata[B_FLAG]) flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_EN]   = en;
        reg_rdata[B_CONT] = cont;
        reg_rdata[B_DMA]  = dma_en;
        reg_rdata[B_LOAD] = ldok;
        reg_rdata[B_FLAG] = flag;
        reg_rdata[B_RUN]  = run;
      end
      A_MOD:  reg_rdata = mod_act;
      A_IDLY: reg_rdata = idly_act;
      A_CHC: begin
        reg_rdata[B_CHEN]  = ch_en;
        reg_rdata[B_CHDLY] = ch_dsel;
      end
      A_CHD:  reg_rdata = cdly_act;
      A_CNT:  reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dly_trig_timer_chk.sv
module dly_trig_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [CW-1:0] reg_wdata,
  input logic          en,
  input logic          cont,
  input logic          run,
  input logic          ldok,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] mod_act,
  input logic          irq,
  input logic          dma_req,
  input logic          pretrig
);
  wire wr_ctrl = reg_we && reg_addr == 3'd0;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= mod_act);
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt != mod_act && !wr_ctrl |=> cnt == $past(cnt) + 1'b1);
  p_cont_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == mod_act && cont && !wr_ctrl |=> run && cnt == '0);
  p_oneshot_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && cnt == mod_act && !cont |=> !run && cnt == '0);
  p_req_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));
  p_ldok_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ldok && !run && !(wr_ctrl && reg_wdata[4]) |=> !ldok);
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq || dma_req |=> flag);
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq && !dma_req && !pretrig);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt == '0);
endmodule

bind dly_trig_timer dly_trig_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .en(en), .cont(cont), .run(run), .ldok(ldok),
  .flag(flag), .cnt(cnt), .mod_act(mod_act), .irq(irq),
  .dma_req(dma_req), .pretrig(pretrig)
);

// File: tb/test_dly_trig_timer.sv
`timescale 1ns/1ps
module test_dly_trig_timer;
  localparam int CW = 16;
  localparam int A_CTRL = 0, A_MOD = 1, A_IDLY = 2, A_CHC = 3, A_CHD = 4, A_CNT = 5;
  localparam int EN = 1, CONT = 2, DMA = 4, TRIG = 8, LOAD = 16, FLAG = 32, RUN = 64;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_addr = 3'd5;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic irq, dma_req, pretrig;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dly_trig_timer #(.CW(CW)) i_dly_trig_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .dma_req(dma_req), .pretrig(pretrig));

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_we = 0; reg_addr = 3'd5;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  function automatic int exp_cnt(int k, int m, bit os);
    if (os) return (k <= m) ? k : 0;
    return k % (m + 1);
  endfunction

  function automatic bit exp_run(int k, int m, bit os);
    return !os || k <= m;
  endfunction

  task automatic start_run(int m, int d, int cd, int mode, bit dma, bit os);
    int c;
    c = EN | (os ? 0 : CONT) | (dma ? DMA : 0);
    wr(A_CTRL, 0);
    wr(A_MOD, m); wr(A_IDLY, d); wr(A_CHD, cd); wr(A_CHC, mode);
    wr(A_CTRL, c | LOAD);
    wr(A_CTRL, c | TRIG);
  endtask

  task automatic obs(int m, int d, int cd, int mode, bit dma, bit os, int n);
    int bc = 0, br = 0, bp = 0;
    for (int k = 0; k < n; k++) begin
      bit r, hit, pt;
      if (k > 0) @(negedge clk);
      reg_addr = 3'd5;
      #1;
      r   = exp_run(k, m, os);
      hit = r && exp_cnt(k, m, os) == d;
      pt  = r && mode[0] && (mode[8] ? exp_cnt(k, m, os) == cd : exp_cnt(k, m, os) == 0);
      if (int'(reg_rdata) != exp_cnt(k, m, os)) bc++;
      if (irq != (hit && !dma) || dma_req != (hit && dma)) br++;
      if (pretrig != pt) bp++;
    end
    chk(os ? "R2" : "R1", "count trace mismatches", bc, 0);
    chk(dma ? "R5" : "R4", "request trace mismatches", br, 0);
    chk("R8", "pre-trigger trace mismatches", bp, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_CTRL, v); chk("R9", "reset control", v, 0);
    rd(A_MOD, v);  chk("R6", "reset modulus", v, 16'hFFFF);
    rd(A_CNT, v);  chk("R9", "reset count", v, 0);
    chk("R9", "reset outputs", {irq, dma_req, pretrig}, 0);

    // directed: delay 1, delay 0, one-shot, DMA, no-delay and disabled pre-trigger
    start_run(9, 1, 3, 'h101, 0, 0); obs(9, 1, 3, 'h101, 0, 0, 25);
    start_run(9, 0, 9, 'h101, 0, 0); obs(9, 0, 9, 'h101, 0, 0, 25);
    start_run(5, 2, 5, 'h101, 0, 1); obs(5, 2, 5, 'h101, 0, 1, 12);
    wr(A_CTRL, EN | TRIG);            obs(5, 2, 5, 'h101, 0, 1, 12); // R2 restart
    start_run(6, 4, 2, 'h001, 1, 0); obs(6, 4, 2, 'h001, 1, 0, 20);
    start_run(3, 3, 1, 'h000, 0, 0); obs(3, 3, 1, 'h000, 0, 0, 12);

    for (int t = 0; t < 10; t++) begin
      int m, d, cd, mode, sel;
      bit dma, os;
      m = 1 + int'($urandom_range(14)); d = int'($urandom_range(m));
      cd = int'($urandom_range(m)); dma = 1'($urandom_range(1));
      os = 1'($urandom_range(1)); sel = int'($urandom_range(2));
      mode = (sel == 0) ? 'h101 : (sel == 1) ? 'h001 : 'h000;
      start_run(m, d, cd, mode, dma, os);
      obs(m, d, cd, mode, dma, os, os ? m + 6 : 3 * (m + 1) + 2);
    end

    // R7 flag: last directed/random runs raised requests
    start_run(4, 1, 0, 'h000, 1, 0); obs(4, 1, 0, 'h000, 1, 0, 6);
    rd(A_CTRL, v); chk("R7", "flag after DMA request", (v >> 5) & 1, 1);
    wr(A_CTRL, FLAG);
    rd(A_CTRL, v); chk("R7", "flag after clear", (v >> 5) & 1, 0);
    repeat (4) @(negedge clk);
    rd(A_CTRL, v); chk("R7", "flag stays clear", (v >> 5) & 1, 0);

    // R6 buffered modulus on a running counter
    start_run(9, 0, 0, 'h101, 0, 0);                          // k=0
    wr(A_MOD, 4);                                              // k=2
    rd(A_MOD, v); chk("R6", "modulus before load", v, 9);      // k=3
    wr(A_CTRL, EN | CONT | LOAD);                              // k=5
    rd(A_CTRL, v); chk("R6", "load pending bit", (v >> 4) & 1, 1); // k=6
    rd(A_MOD, v); chk("R6", "modulus before wrap", v, 9);      // k=7
    rd(A_MOD, v);                                              // k=8
    rd(A_MOD, v); chk("R6", "modulus at last count", v, 9);    // k=9
    rd(A_MOD, v); chk("R6", "modulus after wrap", v, 4);       // k=10
    rd(A_CTRL, v); chk("R6", "load bit cleared", (v >> 4) & 1, 0); // k=11
    rd(A_CNT, v);                                              // k=12
    rd(A_CNT, v);                                              // k=13
    rd(A_CNT, v); chk("R6", "count at new last", v, 4);        // k=14
    rd(A_CNT, v); chk("R6", "count wraps at new modulus", v, 0); // k=15

    // R3 start while running is ignored
    start_run(9, 0, 0, 'h101, 0, 0);
    wr(A_CTRL, EN | CONT | TRIG);
    rd(A_CNT, v); chk("R3", "count after start while running", v, 3);

    // R9 disable while running
    start_run(3, 0, 0, 'h101, 0, 0);
    repeat (2) @(negedge clk);
    wr(A_CTRL, CONT);
    begin
      int bad = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); reg_addr = 3'd5; #1;
        if (reg_rdata != 0 || irq || dma_req || pretrig) bad++;
      end
      chk("R9", "disabled cycles with activity", bad, 0);
    end
    rd(A_CTRL, v); chk("R9", "running bit after disable", (v >> 6) & 1, 0);

    // R3 start without enable
    wr(A_CTRL, CONT | TRIG);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R3", "count after start while disabled", v, 0);
    rd(A_CTRL, v); chk("R3", "running bit after start while disabled", (v >> 6) & 1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule